// File: doc/BRIEF.md
# Image Difference Threshold Pipeline

This block turns two streams of 8-bit grey-level pixels into a two-level (black and white) picture. Each input transfer carries one 128-bit beat from each source image, sixteen pixels per beat, taken from the same positions in both images. For every pixel the block subtracts the first image's intensity from the second's. A pixel whose difference falls outside a window bounded by a low and a high threshold is driven to 0. A pixel whose difference falls inside the window is driven to 255. All sixteen lanes are handled in the same pass.

The datapath is a three-stage pipeline: subtract, compare, select. Both sides use a valid/ready handshake. When the consumer keeps ready high, one beat enters and one beat leaves every cycle. A frame length input gives the number of beats per picture, which is N*N/16 for an N-by-N image. The block marks the final result beat of each frame with a last flag. The two thresholds sit in constant registers that are loaded at reset and never change afterwards.

Top module: `imgdiff_thresh`

## Requirements
- R1: For each lane, the difference is the second image's pixel (`in_b`) minus the first image's pixel (`in_a`), taken as an unsigned 8-bit value modulo 256. For example, 4 minus 5 gives 255 and 4 minus 250 gives 10.
- R2: A lane whose difference is less than 10 outputs 0x00.
- R3: A lane whose difference is greater than 240 outputs 0x00.
- R4: A lane whose difference is from 10 to 240, inclusive, outputs 0xFF.
- R5: Each beat holds sixteen independent lanes. Lane i occupies bits [8i+7:8i] of `in_a`, `in_b` and `out_data`, and one lane never affects another.
- R6: During and directly after reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R7: When `out_ready` is held at 1, a beat accepted at clock edge k shows up on `out_valid`/`out_data` right after edge k+2, and a new beat is accepted on every edge. `in_ready` is 1 whenever `out_ready` is 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values until the transfer takes place.
- R9: `out_last` is 1 on the result of the accepted beat whose position in the frame is `frame_beats`-1, counting from 0. Counting then restarts at 0 for the next frame. Results come out in the order the beats were accepted.
- R10: With `frame_beats` equal to 1, every output beat carries `out_last` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_beats | input | 16 | Beats per frame (at least 1), held constant within a frame |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Block accepts an input beat on this edge |
| in_a | input | 128 | First image beat, sixteen 8-bit pixels |
| in_b | input | 128 | Second image beat, sixteen 8-bit pixels |
| out_valid | output | 1 | Result beat is present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_data | output | 128 | Sixteen result pixels, each 0x00 or 0xFF |
| out_last | output | 1 | Result beat closes a frame |

## Verification
A driver writes each input beat at the falling edge and reads `in_ready` one nanosecond later. The acceptance edge is therefore known before it happens, and the expected result and its acceptance cycle go into a scoreboard at that moment. The monitor samples one nanosecond after each falling edge, when every output is stable. When no stall is applied, it requires each result to appear exactly two cycles after its acceptance edge, as R7 demands. When the consumer stalls, only order and value are checked, and each held beat is compared with its value from the cycle before, as R8 requires. The `out_last` flag is predicted from a frame counter kept in the bench.

// File: rtl/imgdiff_pkg.sv
package imgdiff_pkg;

   // Control word carried alongside the lane data through each stage
   typedef struct packed {
      logic valid;
      logic last;
   } stage_ctl_t;

   localparam stage_ctl_t CTL_IDLE = '{valid: 1'b0, last: 1'b0};

endpackage

// File: rtl/imgdiff_framer.sv
module imgdiff_framer #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [LEN_W-1:0] frame_beats,
   output logic             is_last
);

   logic [LEN_W-1:0] pos_q;

   assign is_last = (pos_q == frame_beats - LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= '0;
      else if (step)
         pos_q <= is_last ? '0 : pos_q + LEN_W'(1);
   end

   // R9: position restarts after the closing beat of a frame
   p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      step && is_last |=> pos_q == '0);

   // R9: position advances by one on every other accepted beat
   p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      step && !is_last |=> pos_q == $past(pos_q) + LEN_W'(1));

endmodule

// File: rtl/imgdiff_lane.sv
module imgdiff_lane #(
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PIX_W-1:0] pix_a,
   input  logic [PIX_W-1:0] pix_b,
   input  logic [PIX_W-1:0] lo_th,
   input  logic [PIX_W-1:0] hi_th,
   output logic [PIX_W-1:0] pix_q
);

   logic [PIX_W-1:0] diff_q;   // stage 1: wrapped difference
   logic             rej_q;    // stage 2: outside the window
   logic [PIX_W-1:0] res_q;    // stage 3: selected constant

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         diff_q <= '0;
         rej_q  <= 1'b1;
         res_q  <= '0;
      end else if (en) begin
         diff_q <= pix_b - pix_a;
         rej_q  <= (diff_q < lo_th) | (diff_q > hi_th);
         res_q  <= rej_q ? {PIX_W{1'b0}} : {PIX_W{1'b1}};
      end
   end

   assign pix_q = res_q;

   // R2/R3: a rejected pixel reaches the output as zero
   p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en && rej_q |=> pix_q == '0);

   // R4: an accepted pixel reaches the output as full scale
   p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en && !rej_q |=> pix_q == {PIX_W{1'b1}});

   // R4: the output of a lane is only ever one of the two constants
   p_twolevel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pix_q == '0 || pix_q == {PIX_W{1'b1}});

endmodule

// File: rtl/imgdiff_thresh.sv
module imgdiff_thresh
   import imgdiff_pkg::*;
#(
   parameter int LANES = 16,
   parameter int PIX_W = 8,
   parameter int LEN_W = 16,
   parameter int LO_TH = 10,
   parameter int HI_TH = 240,
   localparam int BEAT_W = LANES * PIX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  frame_beats,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BEAT_W-1:0] in_a,
   input  logic [BEAT_W-1:0] in_b,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BEAT_W-1:0] out_data,
   output logic              out_last
);

   initial begin
      assert (LANES >= 1) else $error("LANES must be at least 1");
      assert (PIX_W >= 2) else $error("PIX_W must be at least 2");
      assert (LO_TH >= 0 && LO_TH < HI_TH) else $error("thresholds out of order");
      assert (HI_TH < (1 << PIX_W)) else $error("HI_TH exceeds pixel range");
   end

   stage_ctl_t ctl1_q, ctl2_q, ctl3_q;
   logic       adv;
   logic       frame_end;
   logic [PIX_W-1:0] lo_q, hi_q;

   // Whole pipe moves when the output slot is empty or being drained
   assign adv      = !ctl3_q.valid || out_ready;
   assign in_ready = adv;

   // Threshold constants: loaded at reset, held afterwards
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= PIX_W'(LO_TH);
         hi_q <= PIX_W'(HI_TH);
      end else begin
         lo_q <= lo_q;
         hi_q <= hi_q;
      end
   end

   imgdiff_framer #(.LEN_W(LEN_W)) i_framer (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (in_valid && adv),
      .frame_beats (frame_beats),
      .is_last     (frame_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl1_q <= CTL_IDLE;
         ctl2_q <= CTL_IDLE;
         ctl3_q <= CTL_IDLE;
      end else if (adv) begin
         ctl1_q <= '{valid: in_valid, last: in_valid && frame_end};
         ctl2_q <= ctl1_q;
         ctl3_q <= ctl2_q;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      imgdiff_lane #(.PIX_W(PIX_W)) i_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (adv),
         .pix_a (in_a[g*PIX_W +: PIX_W]),
         .pix_b (in_b[g*PIX_W +: PIX_W]),
         .lo_th (lo_q),
         .hi_th (hi_q),
         .pix_q (out_data[g*PIX_W +: PIX_W])
      );
   end

   assign out_valid = ctl3_q.valid;
   assign out_last  = ctl3_q.last;

   // R8: a stalled result holds still
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   // R7: a ready consumer never back-pressures the input
   p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready);

   // R9: the frame flag only rides on a valid result
   p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R6: threshold constants never move after reset
   p_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lo_q == PIX_W'(LO_TH) && hi_q == PIX_W'(HI_TH));

endmodule

// File: tb/test_imgdiff_thresh.sv
`timescale 1ns/1ps
module test_imgdiff_thresh;

   localparam int LANES = 16;
   localparam int PIX_W = 8;
   localparam int BW    = LANES * PIX_W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   frame_beats = 16'd4;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [BW-1:0] in_a = '0, in_b = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [BW-1:0] out_data;
   logic          out_last;

   int tests = 0, fails = 0;
   int cyc = 0;
   bit stall_en = 0, lat_chk = 0, done = 0;
   int tb_pos = 0;

   logic [BW:0] exp_q[$];
   int          acc_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   imgdiff_thresh i_imgdiff_thresh (
      .clk(clk), .rst_n(rst_n), .frame_beats(frame_beats),
      .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last));

   function automatic logic [BW-1:0] model(input logic [BW-1:0] a, input logic [BW-1:0] b);
      logic [BW-1:0] r;
      for (int i = 0; i < LANES; i++) begin
         logic [7:0] d;
         d = b[i*8 +: 8] - a[i*8 +: 8];          // R1 wrap
         r[i*8 +: 8] = (d < 8'd10 || d > 8'd240) ? 8'h00 : 8'hFF;  // R2 R3 R4
      end
      return r;
   endfunction

   function automatic string lane_tag(input logic [BW-1:0] a, input logic [BW-1:0] b,
                                      input logic [BW-1:0] got, input logic [BW-1:0] want);
      for (int i = 0; i < LANES; i++) begin
         if (got[i*8 +: 8] !== want[i*8 +: 8]) begin
            logic [7:0] d;
            d = b[i*8 +: 8] - a[i*8 +: 8];
            if (d < 8'd10)  return "R2/R5";
            if (d > 8'd240) return "R3/R5";
            return "R4/R5";
         end
      end
      return "R1";
   endfunction

   logic [BW-1:0] a_q[$], b_q[$];

   task automatic send(input logic [BW-1:0] a, input logic [BW-1:0] b);
      @(negedge clk);
      in_a = a; in_b = b; in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      tb_pos = tb_pos + 1;
      exp_q.push_back({(tb_pos == int'(frame_beats)), model(a, b)});
      if (tb_pos == int'(frame_beats)) tb_pos = 0;
      acc_q.push_back(cyc + 1);
      a_q.push_back(a); b_q.push_back(b);
      @(posedge clk);
   endtask

   task automatic idle_flush();
      @(negedge clk);
      in_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // Consumer back-pressure
   initial forever begin
      @(negedge clk);
      out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
   end

   // Monitor / scoreboard
   logic [BW-1:0] held_d;
   logic          held_l;
   bit            held = 0;
   initial forever begin
      @(negedge clk);
      #1;
      if (held) begin
         tests++;
         if (!(out_valid && out_data === held_d && out_last === held_l)) begin
            fails++;
            $display("FAIL R8 stalled beat moved: valid=%0b data=%h last=%0b expected data=%h last=%0b",
                     out_valid, out_data, out_last, held_d, held_l);
         end
      end
      held = out_valid && !out_ready;
      held_d = out_data; held_l = out_last;
      if (out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            tests++; fails++;
            $display("FAIL R9 unexpected output beat %h, expected none", out_data);
         end else begin
            logic [BW:0] e;
            logic [BW-1:0] ea, eb;
            int ac;
            e = exp_q.pop_front(); ac = acc_q.pop_front();
            ea = a_q.pop_front(); eb = b_q.pop_front();
            tests++;
            if (out_data !== e[BW-1:0]) begin
               fails++;
               $display("FAIL %s data actual=%h expected=%h", lane_tag(ea, eb, out_data, e[BW-1:0]),
                        out_data, e[BW-1:0]);
            end
            tests++;
            if (out_last !== e[BW]) begin
               fails++;
               $display("FAIL R9/R10 last actual=%0b expected=%0b", out_last, e[BW]);
            end
            if (lat_chk) begin
               tests++;
               if (cyc - ac != 2) begin
                  fails++;
                  $display("FAIL R7 latency actual=%0d expected=2", cyc - ac);
               end
            end
         end
      end
   end

   // Watchdog
   initial begin
      #(5 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired: actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
         $finish;
      end
   end

   initial begin
      // R6 reset state
      #12;
      tests++;
      if (out_valid !== 1'b0 || out_last !== 1'b0 || in_ready !== 1'b1) begin
         fails++;
         $display("FAIL R6 in reset: valid=%0b last=%0b ready=%0b expected 0 0 1",
                  out_valid, out_last, in_ready);
      end
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #1;
      tests++;
      if (out_valid !== 1'b0 || out_last !== 1'b0 || in_ready !== 1'b1) begin
         fails++;
         $display("FAIL R6 after reset: valid=%0b last=%0b ready=%0b expected 0 0 1",
                  out_valid, out_last, in_ready);
      end

      // Boundary lanes, back to back, no stall: R1 R2 R3 R4 R5 R7 R9
      frame_beats = 16'd4; tb_pos = 0; lat_chk = 1;
      send(128'hC8_80_07_1E_14_64_FA_05_00_00_00_01_05_00_00_00,
           128'hD2_80_F7_14_1E_5A_04_04_FF_F1_F0_F0_10_0A_09_00);
      send(128'hD2_80_F7_14_1E_5A_04_04_FF_F1_F0_F0_10_0A_09_00,
           128'hC8_80_07_1E_14_64_FA_05_00_00_00_01_05_00_00_00);
      send({16{8'h00}}, {16{8'h0A}});
      send({16{8'h0B}}, {16{8'h00}});
      send({16{8'h00}}, {16{8'hF0}});
      send({16{8'h00}}, {16{8'hF1}});
      send({8{8'h33, 8'h10}}, {8{8'h3D, 8'hFF}});
      send({16{8'h00}}, {16{8'h09}});
      idle_flush();
      lat_chk = 0;

      // Random beats under back-pressure, frames of 5: R8 R9
      frame_beats = 16'd5; tb_pos = 0; stall_en = 1;
      for (int n = 0; n < 60; n++) begin
         logic [BW-1:0] ra, rb;
         for (int w = 0; w < 4; w++) begin
            ra[w*32 +: 32] = $urandom;
            rb[w*32 +: 32] = $urandom;
         end
         send(ra, rb);
      end
      idle_flush();
      stall_en = 0;

      // Single-beat frames: R10
      frame_beats = 16'd1; tb_pos = 0;
      for (int n = 0; n < 6; n++) send({16{8'(n * 40)}}, {16{8'(n * 7)}});
      idle_flush();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule